// File: doc/BRIEF.md
# ALU with Status and Control Flags Register

This block pairs a combinational arithmetic and logic unit with a registered 16-bit flags word. It takes two operands and a 4-bit operation code and returns the result in the same cycle. It also works out carry, parity, nibble carry, zero, sign and overflow from that result. When the flag-write enable is high and the code is valid, those status bits are loaded into the flags register on the next rising clock edge.

Three mode bits (trap, interrupt enable, direction) sit in the same word. Set and clear strobes change them. The carry bit has its own pair of strobes, and those strobes override the ALU's carry in the cycle they are used. The mode bits are only held and read back: the unit gives them no meaning. Compare works out the same flags as subtract, but the result port reads zero. Shifts and rotates move the operand by one bit position.

Top module: `alu_flags_unit`

## Requirements
- R1: After reset the flags word reads 16'h0002.
- R2: Op 0 (add) gives a+b, and op 1 (subtract) gives a-b, modulo 2^16. Flag bit 0 (carry) is set when the add carries out of bit 15, or when the subtract needs a borrow (a < b unsigned).
- R3: Flag bit 11 (overflow) is set for add when the operands have the same sign and the result's sign differs. For subtract or compare it is set when the operands differ in sign and the result's sign differs from a's sign.
- R4: Flag bit 4 (nibble carry) is set when the low four bits carry out on add, or borrow on subtract or compare. It is 0 for every other operation.
- R5: For every written operation, bit 6 is set when the value is zero, bit 7 copies the value's bit 15, and bit 2 is set when bits 7:0 of the value hold an even number of ones.
- R6: Ops 2, 3, 4 and 5 give AND, OR, XOR and NOT of a. They clear carry, overflow and nibble carry.
- R7: Op 6 shifts left and op 7 shifts right, each by one bit, filling with zero. Op 8 rotates left and op 9 rotates right by one bit. Carry takes the bit moved out of the far end, and overflow is set when bit 15 of the value differs from bit 15 of a.
- R8: Op 10 (compare) writes the same flags as subtract, and the result port reads 0.
- R9: The status bits change only on a clock edge where the flag-write enable is high and the code is 0 to 10. Codes 11 to 15 give a result of 0 and write nothing.
- R10: Strobe index 0 sets or clears carry (bit 0), index 1 trap (bit 8), index 2 interrupt enable (bit 9) and index 3 direction (bit 10). Clear wins over set. A carry strobe wins over an ALU write in the same cycle.
- R11: Bit 1 of the flags word always reads 1. Bits 3, 5 and 15:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_sel | input | 4 | Operation code |
| flag_we | input | 1 | Status flag write enable |
| ctl_set | input | 4 | Set strobes for carry, trap, interrupt enable and direction |
| ctl_clr | input | 4 | Clear strobes, same order, win over set |
| result | output | 16 | Combinational result |
| flags | output | 16 | Registered flags word |

## Verification
The result is combinational, so a wrong operation shows at the result port in the same cycle. A wrong flag computation or a wrong write decision shows in the flags word one edge later. A stale or stuck flag bit stays wrong until something overwrites it, so every bit of the word is compared after every step, not only the bits that step was meant to touch. Directed cases push carry, borrow, signed overflow and nibble carry to their edges. Random cases with sparse strobes catch strobe-priority and hold errors.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int FLAG_W = 16;
  localparam int CTL_N  = 4;

  // fixed flag positions; the layout is decoded by software
  localparam int CF_BIT  = 0;
  localparam int ONE_BIT = 1;
  localparam int PF_BIT  = 2;
  localparam int AF_BIT  = 4;
  localparam int ZF_BIT  = 6;
  localparam int SF_BIT  = 7;
  localparam int TF_BIT  = 8;
  localparam int IF_BIT  = 9;
  localparam int DF_BIT  = 10;
  localparam int OF_BIT  = 11;

  // strobe index -> flag position
  localparam int CTL_CARRY = 0;
  localparam int CTL_POS [CTL_N] = '{CF_BIT, TF_BIT, IF_BIT, DF_BIT};

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR  = 4'd3,
    OP_XOR = 4'd4, OP_NOT = 4'd5, OP_SHL = 4'd6, OP_SHR = 4'd7,
    OP_ROL = 4'd8, OP_ROR = 4'd9, OP_CMP = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } status_t;

  function automatic logic even_ones8(input logic [7:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_flags_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] res,
  output status_t      st,
  output logic         valid
);
  localparam int MSB = W - 1;

  function automatic logic [W:0] add_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [W:0] sub_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  // carry or borrow across the nibble boundary shows up in bit 4
  function automatic logic nib_cross(input logic [W-1:0] x, input logic [W-1:0] y,
                                     input logic [W-1:0] r);
    return x[4] ^ y[4] ^ r[4];
  endfunction

  logic [W-1:0] val;
  logic [W:0]   wide;

  always_comb begin
    val   = '0;
    wide  = '0;
    st    = '0;
    valid = 1'b1;
    case (op)
      OP_ADD: begin
        wide  = add_ext(a, b);
        val   = wide[MSB:0];
        st.cf = wide[W];
        st.af = nib_cross(a, b, val);
        st.of = (a[MSB] == b[MSB]) && (val[MSB] != a[MSB]);
      end
      OP_SUB, OP_CMP: begin
        wide  = sub_ext(a, b);
        val   = wide[MSB:0];
        st.cf = wide[W];
        st.af = nib_cross(a, b, val);
        st.of = (a[MSB] != b[MSB]) && (val[MSB] != a[MSB]);
      end
      OP_AND: val = a & b;
      OP_OR:  val = a | b;
      OP_XOR: val = a ^ b;
      OP_NOT: val = ~a;
      OP_SHL: begin
        val   = {a[MSB-1:0], 1'b0};
        st.cf = a[MSB];
        st.of = a[MSB] ^ val[MSB];
      end
      OP_SHR: begin
        val   = {1'b0, a[MSB:1]};
        st.cf = a[0];
        st.of = a[MSB] ^ val[MSB];
      end
      OP_ROL: begin
        val   = {a[MSB-1:0], a[MSB]};
        st.cf = a[MSB];
        st.of = a[MSB] ^ val[MSB];
      end
      OP_ROR: begin
        val   = {a[0], a[MSB:1]};
        st.cf = a[0];
        st.of = a[MSB] ^ val[MSB];
      end
      default: valid = 1'b0;
    endcase
    st.zf = (val == '0);
    st.sf = val[MSB];
    st.pf = even_ones8(val[7:0]);
    res   = (valid && (op != OP_CMP)) ? val : '0;
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_flags_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  status_t           st,
  input  logic [CTL_N-1:0]  set_s,
  input  logic [CTL_N-1:0]  clr_s,
  output logic [FLAG_W-1:0] word
);
  status_t          sq;
  logic [CTL_N-1:1] mode_q;

  // status bits: ALU write first, carry strobes override
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq <= '0;
    end else begin
      if (wr) sq <= st;
      if (clr_s[CTL_CARRY])      sq.cf <= 1'b0;
      else if (set_s[CTL_CARRY]) sq.cf <= 1'b1;
    end
  end

  // mode bits: strobe-only storage
  for (genvar i = 1; i < CTL_N; i++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q[i] <= 1'b0;
      else if (clr_s[i]) mode_q[i] <= 1'b0;
      else if (set_s[i]) mode_q[i] <= 1'b1;
    end
  end

  always_comb begin
    word          = '0;
    word[ONE_BIT] = 1'b1;
    word[CF_BIT]  = sq.cf;
    word[PF_BIT]  = sq.pf;
    word[AF_BIT]  = sq.af;
    word[ZF_BIT]  = sq.zf;
    word[SF_BIT]  = sq.sf;
    word[OF_BIT]  = sq.of;
    for (int i = 1; i < CTL_N; i++) word[CTL_POS[i]] = mode_q[i];
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        op_sel,
  input  logic              flag_we,
  input  logic [CTL_N-1:0]  ctl_set,
  input  logic [CTL_N-1:0]  ctl_clr,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  status_t core_st;
  logic    op_ok;
  logic    alu_wr;

  alu_core #(.W(DATA_W)) u_core (
    .a     (op_a),
    .b     (op_b),
    .op    (op_sel),
    .res   (result),
    .st    (core_st),
    .valid (op_ok)
  );

  assign alu_wr = flag_we & op_ok;

  flag_reg u_freg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (alu_wr),
    .st    (core_st),
    .set_s (ctl_set),
    .clr_s (ctl_clr),
    .word  (flags)
  );
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
  import alu_flags_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_sel,
  input logic              flag_we,
  input logic [CTL_N-1:0]  ctl_set,
  input logic [CTL_N-1:0]  ctl_clr,
  input logic [W-1:0]      result,
  input logic [FLAG_W-1:0] flags,
  input logic              op_ok
);
  logic is_logic_op;
  logic is_visible_op;
  assign is_logic_op   = (op_sel == OP_AND) || (op_sel == OP_OR) ||
                         (op_sel == OP_XOR) || (op_sel == OP_NOT);
  assign is_visible_op = op_ok && (op_sel != OP_CMP);

  assert_fixed_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flags[ONE_BIT] && !flags[3] && !flags[5] && (flags[15:12] == 4'd0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(flag_we && op_ok) && (ctl_set == '0) && (ctl_clr == '0)) |=> $stable(flags));

  assert_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 4'd10) |-> (result == '0) && !op_ok);

  assert_cmp_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_CMP) |-> (result == '0));

  assert_carry_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr[CTL_CARRY] |=> !flags[CF_BIT]);

  assert_carry_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set[CTL_CARRY] && !ctl_clr[CTL_CARRY]) |=> flags[CF_BIT]);

  assert_logic_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && is_logic_op && !ctl_set[CTL_CARRY]) |=>
      (!flags[CF_BIT] && !flags[OF_BIT] && !flags[AF_BIT]));

  assert_zero_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && is_visible_op) |=>
      ((flags[ZF_BIT] == ($past(result) == '0)) && (flags[SF_BIT] == $past(result[W-1]))));
endmodule

bind alu_flags_unit alu_flags_chk #(.W(DATA_W)) u_flags_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_sel  (op_sel),
  .flag_we (flag_we),
  .ctl_set (ctl_set),
  .ctl_clr (ctl_clr),
  .result  (result),
  .flags   (flags),
  .op_ok   (op_ok)
);

// File: tb/alu_flags_unit_bench.sv
`timescale 1ns/1ps
module alu_flags_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [3:0]  op_sel = '0;
  logic        flag_we = 1'b0;
  logic [3:0]  ctl_set = '0, ctl_clr = '0;
  logic [15:0] result, flags;

  int checks = 0;
  int fails  = 0;
  logic [15:0] mflags = 16'h0002;

  always #2 clk = ~clk;

  alu_flags_unit u_alu_flags_unit (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_we(flag_we), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
    .result(result), .flags(flags)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_value(input logic [15:0] a, b, input logic [3:0] op);
    case (op)
      4'd0: return a + b;
      4'd1, 4'd10: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd5: return ~a;
      4'd6: return a << 1;
      4'd7: return a >> 1;
      4'd8: return (a << 1) | (a >> 15);
      4'd9: return (a >> 1) | (a << 15);
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] m_result(input logic [15:0] a, b, input logic [3:0] op);
    return (op == 4'd10) ? 16'h0000 : m_value(a, b, op);
  endfunction

  // status bits in their word positions, from integer arithmetic
  function automatic logic [15:0] m_status(input logic [15:0] a, b, input logic [3:0] op);
    logic [15:0] v = m_value(a, b, op);
    logic [15:0] w = '0;
    int ia = int'(a), ib = int'(b);
    int sa = int'($signed(a)), sb = int'($signed(b));
    int ones = 0;
    case (op)
      4'd0: begin
        w[0]  = (ia + ib) > 65535;
        w[4]  = ((ia & 15) + (ib & 15)) > 15;
        w[11] = ((sa + sb) > 32767) || ((sa + sb) < -32768);
      end
      4'd1, 4'd10: begin
        w[0]  = ia < ib;
        w[4]  = (ia & 15) < (ib & 15);
        w[11] = ((sa - sb) > 32767) || ((sa - sb) < -32768);
      end
      4'd6, 4'd8: begin w[0] = a[15]; w[11] = a[15] != v[15]; end
      4'd7, 4'd9: begin w[0] = a[0];  w[11] = a[15] != v[15]; end
      default: ;
    endcase
    for (int i = 0; i < 8; i++) ones += int'(v[i]);
    w[2] = (ones % 2) == 0;
    w[6] = (v == 16'h0000);
    w[7] = v[15];
    return w;
  endfunction

  function automatic string bit_tag(input int pos, input logic [3:0] op, input bit wrote,
                                    input logic [3:0] s, input logic [3:0] c);
    bit shift = (op >= 4'd6) && (op <= 4'd9);
    bit logic_op = (op >= 4'd2) && (op <= 4'd5);
    if (pos == 8 || pos == 9 || pos == 10) return "R10";
    if (pos == 0 && (s[0] || c[0])) return "R10";
    if (pos == 1 || pos == 3 || pos == 5 || pos > 11) return "R11";
    if (!wrote) return "R9";
    if (op == 4'd10) return "R8";
    if (pos == 2 || pos == 6 || pos == 7) return "R5";
    if (logic_op) return "R6";
    if (shift) return "R7";
    if (pos == 0) return "R2";
    if (pos == 4) return "R4";
    return "R3";
  endfunction

  task automatic step(input logic [15:0] a, b, input logic [3:0] op, input logic we,
                      input logic [3:0] s, c);
    logic [15:0] nf = mflags;
    logic [15:0] st;
    bit wrote = we && (op <= 4'd10);
    int pos_map [4] = '{0, 8, 9, 10};
    string rtag;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; flag_we = we; ctl_set = s; ctl_clr = c;
    #1;
    rtag = (op > 4'd10) ? "R9" : (op == 4'd10) ? "R8" : (op <= 4'd1) ? "R2" :
           (op <= 4'd5) ? "R6" : "R7";
    check(result === m_result(a, b, op), rtag, $sformatf("result op=%0d", op),
          result, m_result(a, b, op));
    if (wrote) begin
      st = m_status(a, b, op);
      foreach (st[i]) if (i != 8 && i != 9 && i != 10 && i != 1) nf[i] = st[i];
    end
    for (int i = 0; i < 4; i++) begin
      if (c[i]) nf[pos_map[i]] = 1'b0;
      else if (s[i]) nf[pos_map[i]] = 1'b1;
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < 16; i++)
      check(flags[i] === nf[i], bit_tag(i, op, wrote, s, c),
            $sformatf("flag bit %0d op=%0d", i, op), flags, nf);
    mflags = nf;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(flags === 16'h0002, "R1", "reset value", flags, 16'h0002);

    // directed corners
    step(16'hFFFF, 16'h0001, 4'd0, 1, 4'h0, 4'h0); // R2 carry out, zero, R4 nibble carry
    step(16'h7FFF, 16'h0001, 4'd0, 1, 4'h0, 4'h0); // R3 positive overflow
    step(16'h8000, 16'h0001, 4'd1, 1, 4'h0, 4'h0); // R3 negative overflow on subtract
    step(16'h0000, 16'h0001, 4'd1, 1, 4'h0, 4'h0); // R2 borrow
    step(16'h0010, 16'h0001, 4'd1, 1, 4'h0, 4'h0); // R4 nibble borrow
    step(16'h1234, 16'h1234, 4'd10, 1, 4'h0, 4'h0); // R8 equal compare
    step(16'h8001, 16'h0000, 4'd6, 1, 4'h0, 4'h0); // R7 shift left carry out
    step(16'h0001, 16'h0000, 4'd9, 1, 4'h0, 4'h0); // R7 rotate right wraps
    step(16'h00FF, 16'h0F0F, 4'd2, 1, 4'h1, 4'h0); // R10 carry strobe beats logic op
    step(16'hAAAA, 16'h0000, 4'd5, 0, 4'h0, 4'h0); // R9 write disabled
    step(16'h5555, 16'h5555, 4'd13, 1, 4'h0, 4'h0); // R9 bad code
    step(16'h0000, 16'h0000, 4'd0, 0, 4'hE, 4'h0); // R10 mode bits set
    step(16'h0000, 16'h0000, 4'd0, 0, 4'hF, 4'h4); // R10 clear wins
    step(16'h0000, 16'h0000, 4'd0, 0, 4'h0, 4'hF); // R10 all clear

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] s = '0, c = '0;
      if ($urandom_range(0, 3) == 0) begin
        s = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
        c = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      end
      step(16'($urandom), 16'($urandom), 4'($urandom_range(0, 15)),
           ($urandom_range(0, 4) != 0), s, c);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule